// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Unit

This block gathers interrupt causes from a group of channels, keeps one pending flag per cause, and signals the host through an active-low request line. The host answers with an acknowledge strobe. The strobe reaches this block along a priority chain. A chain-enable input, which is active low, says that no device further up the chain is asking for service. While that enable is low and at least one cause is pending, the block returns an 8-bit vector for the winning cause and asserts a transfer acknowledge. If nothing is pending, it drives its own chain-enable output low so that the next device down the chain can answer.

The vector takes its upper bits from a base value that the host programs. Its low bits carry the index of the winning cause. Cause priority rotates. The host programs a lead index, which is the highest-priority cause, and the remaining causes follow it in ascending order, wrapping around. A cause is cleared when its vector is delivered or when the host writes a clear mask. The open-drain request line and the tri-stated data byte are modelled as plain outputs: an active-low level for the request, and a data word paired with an output-enable.

Top module: `irq_daisy_unit`

## Requirements
- R1: After synchronous reset, irq_n=1, ieo_n=1, dtack_n=1 and vec_oe=0. No cause is pending, the base is 0x00 and the lead index is 0.
- R2: A 1 on cause_set[i] at a clock edge makes cause i pending. From the next cycle irq_n is low, and it stays low while any cause is pending.
- R3: clr_wr clears every pending cause whose bit in clr_mask is 1. If cause_set sets the same bit at the same edge, the set wins.
- R4: Suppose iack_n and iei_n are both low at an edge, the unit is idle, and a cause is pending. From the next cycle vec_oe=1 and dtack_n=0, and ieo_n stays 1.
- R5: The delivered vector is base[7:IW] concatenated with the winning cause index in bits IW-1:0. IW = clog2(N_SRC), which is 4 for the default of 9 causes. base_wr loads base_val.
- R6: The winner is the first pending cause found when scanning from the lead index upward, modulo N_SRC. prio_wr loads prio_lead only if its value is below N_SRC; otherwise the old lead is kept.
- R7: One acknowledge cycle delivers exactly one vector. The winning cause is cleared at the grant edge, and vec_data stays stable until iack_n rises.
- R8: If iack_n and iei_n are low at an edge with nothing pending, then from the next cycle ieo_n=0, while dtack_n stays 1 and vec_oe stays 0.
- R9: While iei_n is high, an acknowledge produces no vector and no dtack_n, and ieo_n stays 1.
- R10: The edge after iack_n rises returns vec_oe to 0 and dtack_n to 1.
- R11: Outside a grant, ieo_n is registered as (iei_n OR any cause pending). It is low only when the chain enable-in is low and this unit has nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cause_set | input | N_SRC | Per-cause set pulses |
| clr_wr | input | 1 | Host clear strobe |
| clr_mask | input | N_SRC | Causes to clear when clr_wr is high |
| prio_wr | input | 1 | Lead-index write strobe |
| prio_lead | input | IW | New lead index |
| base_wr | input | 1 | Vector-base write strobe |
| base_val | input | 8 | New vector base |
| iack_n | input | 1 | Acknowledge strobe, active low |
| iei_n | input | 1 | Chain enable in, active low |
| ieo_n | output | 1 | Chain enable out, active low |
| irq_n | output | 1 | Interrupt request, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| vec_data | output | 8 | Vector byte |
| vec_oe | output | 1 | Drive enable for vec_data; 0 means high impedance |

## Verification
The bound checker watches several chain rules on every cycle. A low ieo_n must follow a low iei_n. A vector must never be driven while ieo_n is low. A vector may appear only after an acknowledge with the enable-in low and a request outstanding. It must hold steady while the strobe stays low, and it may drop only after the strobe is released. Which cause wins under a given lead index, the exact vector value, the clear-versus-set race and the rejection of an out-of-range lead can only be shown by the bench's scenarios. The bench compares each of these against its own pending-flag model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_PASS  = 2'd2
  } ack_st_t;

  localparam int VEC_W = 8;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 9,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic             clr_wr_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic             take_i,
  input  logic [IW-1:0]    take_idx_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             any_q_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_nxt;
  logic [N_SRC-1:0] kill;

  // per-cause clear / set, set has priority
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    assign kill[i] = (clr_wr_i & clr_mask_i[i]) |
                     (take_i & (32'(take_idx_i) == i));
    assign pend_nxt[i] = (pend_q[i] & ~kill[i]) | set_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      any_q_o <= 1'b0;
    end else begin
      pend_q  <= pend_nxt;
      any_q_o <= |pend_nxt;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 9,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr_i,
  input  logic [7:0]    base_val_i,
  input  logic          prio_wr_i,
  input  logic [IW-1:0] prio_lead_i,
  output logic [7:0]    base_o,
  output logic [IW-1:0] lead_o
);
  logic lead_ok;
  assign lead_ok = (32'(prio_lead_i) < N_SRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      lead_o <= '0;
    end else begin
      if (base_wr_i)            base_o <= base_val_i;
      if (prio_wr_i && lead_ok) lead_o <= prio_lead_i;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 9,
  parameter int IW    = 4
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [IW-1:0]    lead_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);
  // scan from farthest to nearest so the nearest pending cause wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      int j;
      j = 32'(lead_i) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (pend_i[j]) begin
        hit_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iack_n,
  input  logic          iei_n,
  input  logic          any_i,
  input  logic [IW-1:0] win_idx_i,
  input  logic [7:0]    base_i,
  output logic          take_o,
  output logic          ieo_n,
  output logic          dtack_n,
  output logic [7:0]    vec_data,
  output logic          vec_oe
);
  ack_st_t st_q, st_nxt;
  logic    pass;
  logic [7:0] vec_nxt;

  assign take_o = (st_q == ST_IDLE) & ~iack_n & ~iei_n & any_i;
  assign pass   = (st_q == ST_IDLE) & ~iack_n & ~iei_n & ~any_i;

  always_comb begin
    vec_nxt = base_i;
    vec_nxt[IW-1:0] = win_idx_i;
  end

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE: begin
        if (take_o)    st_nxt = ST_GRANT;
        else if (pass) st_nxt = ST_PASS;
      end
      ST_GRANT, ST_PASS: if (iack_n) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      ieo_n    <= 1'b1;
      dtack_n  <= 1'b1;
      vec_oe   <= 1'b0;
      vec_data <= '0;
    end else begin
      st_q    <= st_nxt;
      ieo_n   <= (st_nxt == ST_GRANT) ? 1'b1 : (iei_n | any_i);
      dtack_n <= ~(st_nxt == ST_GRANT);
      vec_oe  <= (st_nxt == ST_GRANT);
      if (take_o) vec_data <= vec_nxt;
    end
  end
endmodule

// File: rtl/irq_daisy_unit.sv
module irq_daisy_unit #(
  parameter int N_SRC = 9,
  parameter int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cause_set,
  input  logic             clr_wr,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic             prio_wr,
  input  logic [IW-1:0]    prio_lead,
  input  logic             base_wr,
  input  logic [7:0]       base_val,
  input  logic             iack_n,
  input  logic             iei_n,
  output logic             ieo_n,
  output logic             irq_n,
  output logic             dtack_n,
  output logic [7:0]       vec_data,
  output logic             vec_oe
);
  logic [N_SRC-1:0] pend;
  logic             any_q;
  logic             hit;
  logic [IW-1:0]    win_idx;
  logic [7:0]       base_q;
  logic [IW-1:0]    lead_q;
  logic             take;

  irq_pend_bank #(.N_SRC(N_SRC), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .set_i(cause_set), .clr_wr_i(clr_wr),
    .clr_mask_i(clr_mask), .take_i(take), .take_idx_i(win_idx),
    .pend_o(pend), .any_q_o(any_q)
  );

  irq_cfg_regs #(.N_SRC(N_SRC), .IW(IW)) u_cfg (
    .clk(clk), .rst(rst), .base_wr_i(base_wr), .base_val_i(base_val),
    .prio_wr_i(prio_wr), .prio_lead_i(prio_lead),
    .base_o(base_q), .lead_o(lead_q)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .IW(IW)) u_pick (
    .pend_i(pend), .lead_i(lead_q), .hit_o(hit), .idx_o(win_idx)
  );

  irq_chain_ctrl #(.IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .iack_n(iack_n), .iei_n(iei_n), .any_i(hit),
    .win_idx_i(win_idx), .base_i(base_q), .take_o(take),
    .ieo_n(ieo_n), .dtack_n(dtack_n), .vec_data(vec_data), .vec_oe(vec_oe)
  );

  assign irq_n = ~any_q;
endmodule

// File: rtl/irq_daisy_chk.sv
module irq_daisy_chk (
  input logic       clk,
  input logic       rst,
  input logic       iack_n,
  input logic       iei_n,
  input logic       ieo_n,
  input logic       irq_n,
  input logic       dtack_n,
  input logic [7:0] vec_data,
  input logic       vec_oe
);
  assert_ieo_needs_iei_R11: assert property (@(posedge clk) disable iff (rst)
    !ieo_n |-> $past(!iei_n));

  assert_no_vec_when_passing_R8: assert property (@(posedge clk) disable iff (rst)
    !(vec_oe && !ieo_n));

  assert_grant_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_oe) |-> $past(!iack_n && !iei_n && !irq_n));

  assert_vec_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_data));

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(vec_oe) |-> $past(iack_n));

  assert_dtack_pairs_vec_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> $past(!iack_n));
endmodule

bind irq_daisy_unit irq_daisy_chk u_chk (
  .clk(clk), .rst(rst), .iack_n(iack_n), .iei_n(iei_n), .ieo_n(ieo_n),
  .irq_n(irq_n), .dtack_n(dtack_n), .vec_data(vec_data), .vec_oe(vec_oe)
);

// File: tb/irq_daisy_unit_tb.sv
module irq_daisy_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 9;
  localparam int IW = 4;

  logic clk = 0;
  logic rst;
  logic [N-1:0] cause_set;
  logic clr_wr;
  logic [N-1:0] clr_mask;
  logic prio_wr;
  logic [IW-1:0] prio_lead;
  logic base_wr;
  logic [7:0] base_val;
  logic iack_n, iei_n;
  logic ieo_n, irq_n, dtack_n, vec_oe;
  logic [7:0] vec_data;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] pend_m;
  logic [7:0]   base_m;
  int           lead_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_daisy_unit #(.N_SRC(N)) u_dut (
    .clk(clk), .rst(rst), .cause_set(cause_set), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .prio_wr(prio_wr), .prio_lead(prio_lead),
    .base_wr(base_wr), .base_val(base_val), .iack_n(iack_n), .iei_n(iei_n),
    .ieo_n(ieo_n), .irq_n(irq_n), .dtack_n(dtack_n), .vec_data(vec_data),
    .vec_oe(vec_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pick_win(input logic [N-1:0] p, input int lead);
    for (int k = 0; k < N; k++) begin
      int j;
      j = (lead + k) % N;
      if (p[j]) return j;
    end
    return -1;
  endfunction

  function automatic logic [7:0] exp_vec(input int idx);
    return {base_m[7:IW], 4'(idx)};
  endfunction

  task automatic idle_inputs();
    cause_set = '0; clr_wr = 0; clr_mask = '0; prio_wr = 0; prio_lead = '0;
    base_wr = 0; base_val = '0; iack_n = 1; iei_n = 1;
  endtask

  // one cycle of set/clear traffic; R2, R3, R11
  task automatic cyc(input logic [N-1:0] s, input logic cw, input logic [N-1:0] cm,
                     input logic iei, input string tag);
    logic any_old;
    @(negedge clk);
    idle_inputs();
    cause_set = s; clr_wr = cw; clr_mask = cm; iei_n = iei;
    @(negedge clk);
    any_old = |pend_m;
    pend_m = (pend_m & ~(cw ? cm : '0)) | s;
    check(irq_n == ~(|pend_m), {tag, " irq_n R2"}, irq_n, ~(|pend_m));
    check(ieo_n == (iei | any_old), {tag, " ieo_n R11"}, ieo_n, iei | any_old);
  endtask

  task automatic set_lead(input int v);
    @(negedge clk);
    idle_inputs();
    prio_wr = 1; prio_lead = IW'(v);
    @(negedge clk);
    if (v < N) lead_m = v;
  endtask

  task automatic set_base(input logic [7:0] b);
    @(negedge clk);
    idle_inputs();
    base_wr = 1; base_val = b;
    @(negedge clk);
    base_m = b;
  endtask

  // full acknowledge cycle: R4 R5 R6 R7 R8 R9 R10
  task automatic do_ack(input logic iei, input string tag);
    int w;
    logic [7:0] ev;
    logic grant, passd;
    @(negedge clk);
    idle_inputs();
    iack_n = 0; iei_n = iei;
    @(negedge clk);
    w = pick_win(pend_m, lead_m);
    grant = !iei && (w >= 0);
    passd = !iei && (w < 0);
    ev = grant ? exp_vec(w) : 8'h00;
    if (grant) pend_m[w] = 1'b0;
    for (int c = 0; c < 2; c++) begin
      check(vec_oe == grant, {tag, " vec_oe R4/R9"}, vec_oe, grant);
      check(dtack_n == !grant, {tag, " dtack_n R4/R8"}, dtack_n, !grant);
      check(ieo_n == !passd, {tag, " ieo_n R8/R9"}, ieo_n, !passd);
      if (grant) check(vec_data == ev, {tag, " vector R5/R6/R7"}, vec_data, ev);
      check(irq_n == ~(|pend_m), {tag, " cleared R7"}, irq_n, ~(|pend_m));
      if (c == 0) @(negedge clk);
    end
    iack_n = 1; iei_n = 1;
    @(negedge clk);
    check(vec_oe == 0, {tag, " release vec_oe R10"}, vec_oe, 0);
    check(dtack_n == 1, {tag, " release dtack_n R10"}, dtack_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst = 1;
    pend_m = '0; base_m = 8'h00; lead_m = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(irq_n == 1, "reset irq_n R1", irq_n, 1);
    check(ieo_n == 1, "reset ieo_n R1", ieo_n, 1);
    check(dtack_n == 1, "reset dtack_n R1", dtack_n, 1);
    check(vec_oe == 0, "reset vec_oe R1", vec_oe, 0);
    do_ack(1'b0, "reset pass R1");

    // R2 R4 R5 basic grant
    set_base(8'hA7);
    cyc(9'b000001000, 0, '0, 1, "set3");
    do_ack(1'b0, "grant3");

    // R6 rotating priority and rejected lead
    cyc(9'b100100100, 0, '0, 1, "set2_5_8");
    set_lead(6);
    do_ack(1'b0, "lead6 wins8");
    set_lead(12);
    do_ack(1'b0, "lead12 ignored R6");
    set_lead(0);
    do_ack(1'b0, "lead0 wins5");

    // R3 clear and set-wins race
    cyc(9'b000010010, 0, '0, 1, "set1_4");
    cyc(9'b000010000, 1, 9'b000010010, 1, "clear race R3");
    do_ack(1'b0, "after race R3");

    // R9 enable-in high blocks response
    cyc(9'b000000001, 0, '0, 1, "set0");
    do_ack(1'b1, "iei high R9");
    do_ack(1'b0, "grant0");

    // R11 idle chain pass-through
    cyc('0, 0, '0, 0, "idle iei low R11");
    cyc(9'b010000000, 0, '0, 0, "set7 iei low R11");
    cyc('0, 0, '0, 0, "pend iei low R11");
    cyc('0, 1, 9'b111111111, 1, "clear all R3");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom % 8;
      case (r)
        0, 1, 2: cyc(N'($urandom) & N'($urandom), 0, '0, 1'($urandom), "rand set");
        3: cyc(N'($urandom) & N'($urandom), 1, N'($urandom), 1, "rand clr R3");
        4, 5: do_ack(1'b0, "rand ack");
        6: if ($urandom % 2 == 0) do_ack(1'b1, "rand blocked R9");
           else set_lead(int'($urandom % 16));
        default: set_base(8'($urandom));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule